// File: doc/BRIEF.md
# Named Barrier Synchronization Unit

This unit keeps a bank of hardware barriers for one workgroup. Software first sizes the bank, then gives each barrier a participant count. Threads are tied to a barrier. The unit counts the arrivals on that barrier, and each thread records separately which barrier it is waiting on. When a barrier has collected its participant count, every thread waiting on it gets a one-cycle release pulse. The barrier's counter then clears, so the same barrier serves the next producer/consumer phase.

Commands come in one at a time through a command port: allocate, initialize, bind, wait. Arrivals come in on a separate per-thread vector, so several threads can arrive in the same cycle. A command or arrival that names an identifier outside the allocated range sets a sticky error flag and changes nothing else.

Top module: `nbar_unit`

## Requirements
- R1: After reset no release is pulsed, the error flag is low and no barrier identifier is allocated.
- R2: `cmd_op_i` = 0 (allocate) makes identifiers 0 to `cmd_arg_i`-1 valid and clears every arrival counter. An argument above the bank size allocates the whole bank.
- R3: `cmd_op_i` = 1 (initialize) loads `cmd_arg_i` as the participant count of barrier `cmd_bid_i` and clears its arrival counter.
- R4: `cmd_op_i` = 2 (bind) ties thread `cmd_tid_i` to barrier `cmd_bid_i`. Later arrivals from that thread count toward that barrier. Any number of threads may share one barrier.
- R5: A barrier completes on the clock edge where at least one arrival lands and the arrivals counted so far reach its participant count. Each thread then waiting on it sees `release_o` high for exactly the one cycle after that edge.
- R6: All arrivals that hit the same barrier in one cycle are counted together.
- R7: A barrier's counter is zero after it completes, so the next phase needs the full participant count again.
- R8: `cmd_op_i` = 3 (wait) records that thread `cmd_tid_i` waits on `cmd_bid_i`. A wait issued on the completing edge or later is held until the following completion.
- R9: A wait, bind or initialize whose identifier is not below the allocated count, or an arrival from a thread whose bound barrier is not allocated, sets `err_o`. `err_o` stays set until reset, and the command or arrival has no other effect.
- R10: A thread that is not waiting, or that waits on another barrier, is not released by a completion.
- R11: An initialize on the same edge as arrivals to that barrier wins: the arrivals are dropped and no completion happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_op_i | input | 2 | 0 allocate, 1 initialize, 2 bind, 3 wait |
| cmd_tid_i | input | $clog2(NT) | Issuing thread |
| cmd_bid_i | input | ID_W | Barrier identifier |
| cmd_arg_i | input | CNT_W | Allocation size or participant count |
| arrive_i | input | NT | Per-thread arrival strobe |
| release_o | output | NT | Per-thread release pulse |
| err_o | output | 1 | Sticky range error |

## Verification
If an arrival counter is wrong, its barrier releases its waiters too early or too late. This shows on `release_o` at the very edge where the reference model expects the completion, or it shows in a later phase when the barrier is reused. A lost or wrongly kept wait record releases the wrong thread, or no thread, at the next completion. A missed range check shows on `err_o` one cycle after the bad command. It may also show later as a release that should not have happened.

// File: rtl/nbar_pkg.sv
package nbar_pkg;
    typedef enum logic [1:0] {
        OP_ALLOC = 2'd0,
        OP_INIT  = 2'd1,
        OP_BIND  = 2'd2,
        OP_WAIT  = 2'd3
    } nbar_op_e;
endpackage

// File: rtl/nbar_tally.sv
// Counts, per barrier, how many accepted arrivals hit it this cycle.
module nbar_tally #(
    parameter int NT    = 8,
    parameter int NB    = 32,
    parameter int BID_W = 5,
    parameter int HIT_W = 4
) (
    input  logic [NT-1:0]             arr_ok_i,
    input  logic [NT-1:0][BID_W-1:0]  bound_i,
    output logic [NB-1:0][HIT_W-1:0]  hits_o
);
    for (genvar b = 0; b < NB; b++) begin : g_bar
        logic [HIT_W-1:0] acc;
        always_comb begin
            acc = '0;
            for (int t = 0; t < NT; t++) begin
                if (arr_ok_i[t] && bound_i[t] == BID_W'(b)) acc = acc + 1'b1;
            end
        end
        assign hits_o[b] = acc;
    end
endmodule

// File: rtl/nbar_wait_table.sv
// Per-thread wait record and registered release pulse.
module nbar_wait_table #(
    parameter int NT    = 8,
    parameter int NB    = 32,
    parameter int BID_W = 5,
    parameter int TID_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_i,
    input  logic [TID_W-1:0] set_tid_i,
    input  logic [BID_W-1:0] set_bid_i,
    input  logic [NB-1:0]    done_i,
    output logic [NT-1:0]    release_o
);
    typedef struct packed {
        logic [NT-1:0]            waiting;
        logic [NT-1:0][BID_W-1:0] wbid;
        logic [NT-1:0]            rel;
    } wt_state_t;

    wt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int t = 0; t < NT; t++) begin
            st_d.rel[t]     = st_q.waiting[t] && done_i[st_q.wbid[t]];
            st_d.waiting[t] = st_q.waiting[t] && !st_d.rel[t];
            if (set_i && set_tid_i == TID_W'(t)) begin
                st_d.waiting[t] = 1'b1;
                st_d.wbid[t]    = set_bid_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign release_o = st_q.rel;

    for (genvar t = 0; t < NT; t++) begin : g_chk
        // R10
        rel_needs_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
            release_o[t] |-> $past(st_q.waiting[t]));
    end
endmodule

// File: rtl/nbar_unit.sv
module nbar_unit
    import nbar_pkg::*;
#(
    parameter int NT    = 8,
    parameter int NB    = 32,
    parameter int CNT_W = 8,
    parameter int ID_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_valid_i,
    input  logic [1:0]               cmd_op_i,
    input  logic [$clog2(NT)-1:0]    cmd_tid_i,
    input  logic [ID_W-1:0]          cmd_bid_i,
    input  logic [CNT_W-1:0]         cmd_arg_i,
    input  logic [NT-1:0]            arrive_i,
    output logic [NT-1:0]            release_o,
    output logic                     err_o
);
    localparam int TID_W = $clog2(NT);
    localparam int BID_W = $clog2(NB);
    localparam int AW    = $clog2(NB + 1);
    localparam int HIT_W = $clog2(NT + 1);

    typedef struct packed {
        logic [AW-1:0]            alloc_n;
        logic                     err;
        logic [NB-1:0][CNT_W-1:0] cnt;
        logic [NB-1:0][CNT_W-1:0] part;
        logic [NT-1:0][BID_W-1:0] bound;
    } nb_state_t;

    nb_state_t st_d, st_q;

    nbar_op_e                 op;
    logic                     bid_ok, is_alloc, is_init, is_bind, is_wait, bad_cmd;
    logic [BID_W-1:0]         bid_lo;
    logic [NT-1:0]            arr_ok;
    logic [NB-1:0][HIT_W-1:0] hits;
    logic [NB-1:0]            done;
    logic [NB-1:0]            init_hit;

    always_comb begin
        op       = nbar_op_e'(cmd_op_i);
        bid_ok   = cmd_bid_i < ID_W'(st_q.alloc_n);
        bid_lo   = cmd_bid_i[BID_W-1:0];
        is_alloc = cmd_valid_i && op == OP_ALLOC;
        is_init  = cmd_valid_i && op == OP_INIT && bid_ok;
        is_bind  = cmd_valid_i && op == OP_BIND && bid_ok;
        is_wait  = cmd_valid_i && op == OP_WAIT && bid_ok;
        bad_cmd  = cmd_valid_i && op != OP_ALLOC && !bid_ok;
        for (int t = 0; t < NT; t++) begin
            arr_ok[t] = arrive_i[t] && (AW'(st_q.bound[t]) < st_q.alloc_n);
        end
    end

    nbar_tally #(.NT(NT), .NB(NB), .BID_W(BID_W), .HIT_W(HIT_W)) u_tally (
        .arr_ok_i (arr_ok),
        .bound_i  (st_q.bound),
        .hits_o   (hits)
    );

    always_comb begin
        logic [CNT_W:0] sum;
        st_d = st_q;
        st_d.err = st_q.err | bad_cmd | (|(arrive_i & ~arr_ok));
        for (int b = 0; b < NB; b++) begin
            init_hit[b] = is_init && bid_lo == BID_W'(b);
            sum         = {1'b0, st_q.cnt[b]} + (CNT_W + 1)'(hits[b]);
            done[b]     = (hits[b] != '0) && (sum >= {1'b0, st_q.part[b]})
                          && !init_hit[b] && !is_alloc;
            st_d.cnt[b] = done[b] ? '0 : sum[CNT_W-1:0];
            if (is_alloc) st_d.cnt[b] = '0;
            if (init_hit[b]) begin
                st_d.cnt[b]  = '0;
                st_d.part[b] = cmd_arg_i;
            end
        end
        if (is_alloc) begin
            st_d.alloc_n = (int'(cmd_arg_i) > NB) ? AW'(NB) : AW'(cmd_arg_i);
        end
        if (is_bind) st_d.bound[cmd_tid_i] = bid_lo;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    nbar_wait_table #(.NT(NT), .NB(NB), .BID_W(BID_W), .TID_W(TID_W)) u_wait (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (is_wait),
        .set_tid_i (cmd_tid_i),
        .set_bid_i (bid_lo),
        .done_i    (done),
        .release_o (release_o)
    );

    assign err_o = st_q.err;

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);
    // R9
    bad_wait_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_op_i == 2'd3 && cmd_bid_i >= ID_W'(st_q.alloc_n)) |=> err_o);
    // R2
    alloc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.alloc_n <= AW'(NB));
    for (genvar b = 0; b < NB; b++) begin : g_chk
        // R7
        cnt_below_part_chk: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.cnt[b] == '0 || st_q.cnt[b] < st_q.part[b]);
    end
endmodule

// File: tb/nbar_unit_tb.sv
module nbar_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 8;
    localparam int NB = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid_i = 1'b0;
    logic [1:0]    cmd_op_i = '0;
    logic [2:0]    cmd_tid_i = '0;
    logic [7:0]    cmd_bid_i = '0;
    logic [7:0]    cmd_arg_i = '0;
    logic [NT-1:0] arrive_i = '0;
    logic [NT-1:0] release_o;
    logic          err_o;

    nbar_unit u_dut (.*);

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_cmp = 0, n_bad = 0;
    string tag = "R1";

    // behavioural reference model
    int m_cnt[NB], m_part[NB], m_hits[NB], m_bound[NT], m_wbid[NT];
    bit m_done[NB], m_wait[NT], m_rel[NT];
    int m_alloc;
    bit m_err;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_cnt[b]) begin m_cnt[b] = 0; m_part[b] = 0; end
            foreach (m_bound[t]) begin m_bound[t] = 0; m_wbid[t] = 0; m_wait[t] = 0; m_rel[t] = 0; end
            m_alloc = 0; m_err = 0;
        end else begin
            foreach (m_hits[b]) m_hits[b] = 0;
            for (int t = 0; t < NT; t++)
                if (arrive_i[t]) begin
                    if (m_bound[t] < m_alloc) m_hits[m_bound[t]]++;
                    else m_err = 1;
                end
            for (int b = 0; b < NB; b++)
                m_done[b] = m_hits[b] > 0 && m_cnt[b] + m_hits[b] >= m_part[b]
                    && !(cmd_valid_i && cmd_op_i == 1 && int'(cmd_bid_i) == b && b < m_alloc)
                    && !(cmd_valid_i && cmd_op_i == 0);
            for (int t = 0; t < NT; t++) begin
                m_rel[t] = m_wait[t] && m_done[m_wbid[t]];
                if (m_rel[t]) m_wait[t] = 0;
            end
            for (int b = 0; b < NB; b++) m_cnt[b] = m_done[b] ? 0 : m_cnt[b] + m_hits[b];
            if (cmd_valid_i) begin
                if (cmd_op_i == 0) begin
                    m_alloc = (int'(cmd_arg_i) > NB) ? NB : int'(cmd_arg_i);
                    foreach (m_cnt[b]) m_cnt[b] = 0;
                end else if (int'(cmd_bid_i) >= m_alloc) m_err = 1;
                else if (cmd_op_i == 1) begin m_cnt[cmd_bid_i] = 0; m_part[cmd_bid_i] = int'(cmd_arg_i); end
                else if (cmd_op_i == 2) m_bound[cmd_tid_i] = int'(cmd_bid_i);
                else begin m_wait[cmd_tid_i] = 1; m_wbid[cmd_tid_i] = int'(cmd_bid_i); end
            end
        end
    end

    always @(negedge clk) begin
        for (int t = 0; t < NT; t++) begin
            n_cmp++;
            if (release_o[t] !== m_rel[t]) begin
                n_bad++;
                $display("FAIL %s release_o[%0d] actual=%b expected=%b", tag, t, release_o[t], m_rel[t]);
            end
        end
        n_cmp++;
        if (err_o !== m_err) begin
            n_bad++;
            $display("FAIL %s err_o actual=%b expected=%b", tag, err_o, m_err);
        end
    end

    task automatic step(input bit v, input int op, input int tid, input int bid,
                        input int arg, input logic [NT-1:0] arr);
        cmd_valid_i = v; cmd_op_i = 2'(op); cmd_tid_i = 3'(tid);
        cmd_bid_i = 8'(bid); cmd_arg_i = 8'(arg); arrive_i = arr;
        @(negedge clk);
        cmd_valid_i = 1'b0; arrive_i = '0;
    endtask

    task automatic cmd(input int op, input int tid, input int bid, input int arg);
        step(1, op, tid, bid, arg, '0);
    endtask

    task automatic arr(input logic [NT-1:0] m);
        step(0, 0, 0, 0, 0, m);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, '0);
    endtask

    initial begin
        int wd = 0;
        while (wd < 20000) begin @(posedge clk); wd++; end
        n_bad++;
        $display("watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tag = "R1"; idle(3);
        tag = "R2"; cmd(0, 0, 0, 4);
        tag = "R3"; cmd(1, 0, 0, 2); cmd(1, 0, 1, 3); cmd(1, 0, 2, 1);
        tag = "R4"; cmd(2, 0, 0, 0); cmd(2, 1, 0, 0); cmd(2, 2, 1, 0);
        cmd(2, 3, 1, 0); cmd(2, 4, 1, 0); cmd(2, 5, 2, 0);
        tag = "R5"; cmd(3, 0, 0, 0); cmd(3, 1, 0, 0);
        arr(8'b0000_0001); idle(1); arr(8'b0000_0010); idle(2);
        tag = "R6"; cmd(3, 2, 1, 0); cmd(3, 3, 1, 0);
        arr(8'b0001_1100); idle(2);
        tag = "R7"; cmd(3, 0, 0, 0);
        arr(8'b0000_0001); arr(8'b0000_0001); idle(2);
        tag = "R8"; arr(8'b0000_0001);
        step(1, 3, 0, 0, 0, 8'b0000_0010); idle(1);
        arr(8'b0000_0011); idle(2);
        tag = "R10"; cmd(3, 6, 1, 0); cmd(3, 7, 2, 0);
        arr(8'b0000_0011); idle(1);
        arr(8'b0010_0000); idle(1);
        arr(8'b0001_1100); idle(2);
        tag = "R11"; cmd(3, 0, 0, 0); arr(8'b0000_0001);
        step(1, 1, 0, 0, 2, 8'b0000_0010); idle(1);
        arr(8'b0000_0001); idle(1); arr(8'b0000_0010); idle(2);
        tag = "R2"; cmd(0, 0, 0, 200); cmd(1, 0, 31, 1); cmd(2, 7, 31, 0);
        cmd(3, 6, 31, 0); arr(8'b1000_0000); idle(2);
        tag = "R9"; cmd(3, 6, 31, 0); cmd(3, 6, 40, 0);
        cmd(2, 7, 99, 0); cmd(1, 0, 31, 9);
        arr(8'b1000_0000); idle(2);
        cmd(0, 0, 0, 2); cmd(3, 5, 1, 0); arr(8'b1000_0000); idle(2);
        rst_n = 1'b0; idle(2); rst_n = 1'b1;
        tag = "R1"; idle(2);
        tag = "R9"; arr(8'b0000_0001); idle(2);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule